// File: doc/BRIEF.md
# Comparator event interrupt controller

This block holds the digital control and status logic that sits next to an analog comparator. It brings the comparator's asynchronous digital output into the clock domain, watches it for the event picked by a two-bit mode field (any change, a falling edge or a rising edge), and records a matching event in a sticky flag. When the flag is set and both the block's own interrupt enable and the processor's global interrupt enable are on, it raises an interrupt request. The flag is cleared either when the processor takes the interrupt vector (an acknowledge pulse) or by a write of one to the flag.

The block also steers the comparator's negative input. Normally the fixed dedicated pin is used. When the multiplexer-enable control bit is set and the converter is switched off, the negative input is borrowed from the converter's channel multiplexer and the channel number given on the select input is passed through. The comparator itself, the converter and the processor are outside the block and appear only as plain inputs.

Events are found by comparing a mode-qualified copy of the synchronized comparator level with its value one cycle earlier. Because the qualification depends on the mode, rewriting the mode can itself produce an event; software is expected to turn the local enable off around a mode change.

Top module: `cmpirq_top`

## Requirements
- R1: Mode code 2'b00 sets the flag on any change of the comparator level, 2'b10 on a 1-to-0 change, 2'b11 on a 0-to-1 change; the flag reads one on the third rising clock edge after the change of `cmpRaw` (two synchronizer flops, then the flag register).
- R2: Mode code 2'b01 is reserved and never sets the flag, whatever the comparator does.
- R3: Once set, the flag stays one until a clear takes effect.
- R4: An `vecAck` pulse clears the flag at the next clock edge.
- R5: A `flagWrStb` pulse with `flagWrBit` = 1 clears the flag; with `flagWrBit` = 0 it leaves the flag unchanged.
- R6: When an event and a clear fall in the same cycle, the flag ends up set.
- R7: `irqReq` is one exactly while the flag, the local enable (`cfgIe` as last written) and `globalIe` are all one.
- R8: `negUseMux` is one only while the stored multiplexer-enable bit is one and `adcEn` is zero; then `negChan` equals `muxChan`, otherwise `negChan` is zero and the fixed pin is used.
- R9: Rewriting the mode can raise the flag with no comparator change (for example rising to falling with the comparator low); with the local enable on this yields an interrupt request, while turning the enable off around the change and clearing the flag afterwards yields none.
- R10: `cmpStatus` shows the comparator level two clock edges after `cmpRaw` changes.
- R11: After reset the flag, mode, local enable and multiplexer-enable bit are all zero, so `irqReq`, `negUseMux` and `negChan` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmpRaw | input | 1 | Asynchronous comparator output |
| cfgWe | input | 1 | Write strobe for the control fields below |
| cfgMode | input | 2 | Event mode to store |
| cfgIe | input | 1 | Local interrupt enable to store |
| cfgMuxEn | input | 1 | Multiplexer-enable bit to store |
| flagWrStb | input | 1 | Write strobe for the flag bit |
| flagWrBit | input | 1 | Value written to the flag; one clears it |
| vecAck | input | 1 | Interrupt vector taken |
| globalIe | input | 1 | Processor global interrupt enable |
| adcEn | input | 1 | Converter is switched on |
| muxChan | input | 4 | Converter multiplexer channel select |
| flag | output | 1 | Sticky event flag |
| irqReq | output | 1 | Interrupt request |
| cmpStatus | output | 1 | Synchronized comparator level |
| negUseMux | output | 1 | Negative input taken from the multiplexer |
| negChan | output | 4 | Channel routed to the negative input, zero when unused |

## Verification
The assertions take the flag clear and event strobes to be single-cycle pulses sampled on the clock, and they assume `cmpRaw` is either held long enough to pass both synchronizer flops or deliberately changed in a known phase. The stimulus drives every input at the falling clock edge, holds the comparator level steady for several cycles before each mode write, and clears any flag left by that write before applying the transition under test, so each expected value follows from the mode and the start and end levels alone. The one place the bench breaks the mode-change rule on purpose is the R9 case.

// File: rtl/cmpirq_pkg.sv
package cmpirq_pkg;
  typedef enum logic [1:0] {
    MODE_TOGGLE = 2'b00,
    MODE_RSV    = 2'b01,
    MODE_FALL   = 2'b10,
    MODE_RISE   = 2'b11
  } evtMode_e;

  typedef struct packed {
    logic     flagClr;
    evtMode_e mode;
  } ctlStrobe_t;
endpackage

// File: rtl/cmpirq_datapath.sv
module cmpirq_datapath
  import cmpirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmpRaw,
  input  ctlStrobe_t ctl,
  output logic       cmpSync,
  output logic       flag
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic qualLvl, qualPrev, evtHit;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= cmpRaw;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[i] <= 1'b0;
          else       syncChain[i] <= syncChain[i-1];
      end
    end
  endgenerate

  assign cmpSync = syncChain[LAST];

  // Mode-qualified level: falling mode looks at the inverted level.
  assign qualLvl = (ctl.mode == MODE_FALL) ? ~cmpSync : cmpSync;

  always_comb begin
    unique case (ctl.mode)
      MODE_TOGGLE: evtHit = qualLvl ^ qualPrev;
      MODE_RSV:    evtHit = 1'b0;
      default:     evtHit = qualLvl & ~qualPrev;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qualPrev <= 1'b0;
      flag     <= 1'b0;
    end else begin
      qualPrev <= qualLvl;
      if (evtHit)           flag <= 1'b1;   // set wins over clear
      else if (ctl.flagClr) flag <= 1'b0;
    end
  end

  a_r1_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    evtHit |=> flag);
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !ctl.flagClr) |=> flag);
  a_r4_clear: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.flagClr && !evtHit) |=> !flag);
  a_r2_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.mode == MODE_RSV && !flag) |=> !flag);
  a_r10_status: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmpSync) |-> $past(syncChain[0]));
endmodule

// File: rtl/cmpirq_control.sv
module cmpirq_control
  import cmpirq_pkg::*;
#(
  parameter int CHAN_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgMode,
  input  logic              cfgIe,
  input  logic              cfgMuxEn,
  input  logic              flagWrStb,
  input  logic              flagWrBit,
  input  logic              vecAck,
  input  logic              globalIe,
  input  logic              adcEn,
  input  logic [CHAN_W-1:0] muxChan,
  input  logic              flag,
  output ctlStrobe_t        ctl,
  output logic              irqReq,
  output logic              negUseMux,
  output logic [CHAN_W-1:0] negChan
);
  evtMode_e modeReg;
  logic     ieReg, muxEnReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= MODE_TOGGLE;
      ieReg    <= 1'b0;
      muxEnReg <= 1'b0;
    end else if (cfgWe) begin
      modeReg  <= evtMode_e'(cfgMode);
      ieReg    <= cfgIe;
      muxEnReg <= cfgMuxEn;
    end
  end

  assign ctl.mode    = modeReg;
  assign ctl.flagClr = vecAck | (flagWrStb & flagWrBit);

  assign irqReq    = flag & ieReg & globalIe;
  assign negUseMux = muxEnReg & ~adcEn;
  assign negChan   = negUseMux ? muxChan : '0;

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (globalIe && flag));
  a_r8_adc_owns_mux: assert property (@(posedge clk) disable iff (!rstN)
    negUseMux |-> !adcEn);
  a_r8_chan_idle: assert property (@(posedge clk) disable iff (!rstN)
    !negUseMux |-> (negChan == '0));
  a_r5_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (flagWrStb && flagWrBit) |-> ctl.flagClr);
endmodule

// File: rtl/cmpirq_top.sv
module cmpirq_top
  import cmpirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CHAN_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmpRaw,
  input  logic              cfgWe,
  input  logic [1:0]        cfgMode,
  input  logic              cfgIe,
  input  logic              cfgMuxEn,
  input  logic              flagWrStb,
  input  logic              flagWrBit,
  input  logic              vecAck,
  input  logic              globalIe,
  input  logic              adcEn,
  input  logic [CHAN_W-1:0] muxChan,
  output logic              flag,
  output logic              irqReq,
  output logic              cmpStatus,
  output logic              negUseMux,
  output logic [CHAN_W-1:0] negChan
);
  ctlStrobe_t ctl;

  cmpirq_control #(.CHAN_W(CHAN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgMode(cfgMode), .cfgIe(cfgIe),
    .cfgMuxEn(cfgMuxEn), .flagWrStb(flagWrStb), .flagWrBit(flagWrBit),
    .vecAck(vecAck), .globalIe(globalIe), .adcEn(adcEn), .muxChan(muxChan),
    .flag(flag), .ctl(ctl), .irqReq(irqReq), .negUseMux(negUseMux),
    .negChan(negChan)
  );

  cmpirq_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .cmpRaw(cmpRaw), .ctl(ctl),
    .cmpSync(cmpStatus), .flag(flag)
  );
endmodule

// File: tb/cmpirq_top_tb_top.sv
`timescale 1ns/1ps
module cmpirq_top_tb_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic cmpRaw = 0, cfgWe = 0, cfgIe = 0, cfgMuxEn = 0;
  logic [1:0] cfgMode = 2'b00;
  logic flagWrStb = 0, flagWrBit = 0, vecAck = 0, globalIe = 0, adcEn = 0;
  logic [3:0] muxChan = 4'd0;
  logic flag, irqReq, cmpStatus, negUseMux;
  logic [3:0] negChan;
  int nVec = 0, nBad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cmpirq_top dut_i (.*);

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] m, input logic ie, input logic mx);
    cfgWe = 1; cfgMode = m; cfgIe = ie; cfgMuxEn = mx;
    tick(1);
    cfgWe = 0;
  endtask

  task automatic w1c(input logic b);
    flagWrStb = 1; flagWrBit = b;
    tick(1);
    flagWrStb = 0; flagWrBit = 0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nVec++; nBad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    tick(3);
    // R11 reset state
    chk("R11 flag", {3'b0, flag}, 4'd0);
    chk("R11 irq", {3'b0, irqReq}, 4'd0);
    chk("R11 negUseMux", {3'b0, negUseMux}, 4'd0);
    chk("R11 negChan", negChan, 4'd0);
    rstN = 1;
    tick(2);
    globalIe = 1;

    // R1/R2/R10 sweep over mode x start x end
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 2; s++)
        for (int e = 0; e < 2; e++) begin
          logic expF;
          cmpRaw = s[0];
          tick(4);
          cfg(m[1:0], 1'b0, 1'b0);
          tick(2);
          w1c(1'b1);
          chk("R5 cleared", {3'b0, flag}, 4'd0);
          cmpRaw = e[0];
          tick(2);
          chk("R10 status", {3'b0, cmpStatus}, {3'b0, e[0]});
          chk("R1 no early flag", {3'b0, flag}, 4'd0);
          tick(1);
          case (m)
            0: expF = (s != e);
            1: expF = 1'b0;
            2: expF = s[0] & ~e[0];
            default: expF = ~s[0] & e[0];
          endcase
          chk(m == 1 ? "R2 reserved" : "R1 event", {3'b0, flag}, {3'b0, expF});
          tick(3);
          chk("R3 sticky", {3'b0, flag}, {3'b0, expF});
        end

    // R5 write zero, R4 ack
    cmpRaw = 0; tick(4);
    cfg(2'b11, 1'b0, 1'b0); tick(2); w1c(1'b1);
    cmpRaw = 1; tick(3);
    chk("R1 rise", {3'b0, flag}, 4'd1);
    w1c(1'b0);
    chk("R5 write zero", {3'b0, flag}, 4'd1);
    vecAck = 1; tick(1); vecAck = 0;
    chk("R4 ack", {3'b0, flag}, 4'd0);

    // R6 set beats clear, both clear sources
    for (int src = 0; src < 2; src++) begin
      cmpRaw = 0; tick(4); w1c(1'b1);
      cmpRaw = 1; tick(2);
      if (src == 0) vecAck = 1; else begin flagWrStb = 1; flagWrBit = 1; end
      tick(1);
      vecAck = 0; flagWrStb = 0; flagWrBit = 0;
      chk("R6 set priority", {3'b0, flag}, 4'd1);
    end

    // R7 irq sweep
    for (int k = 0; k < 8; k++) begin
      cmpRaw = 0; tick(4);
      cfg(2'b11, k[1], 1'b0); tick(2); w1c(1'b1);
      globalIe = k[2];
      if (k[0]) begin cmpRaw = 1; tick(3); end
      tick(1);
      chk("R7 irq", {3'b0, irqReq}, {3'b0, k[0] & k[1] & k[2]});
    end
    globalIe = 1;

    // R8 mux sweep
    for (int k = 0; k < 64; k++) begin
      cfg(2'b01, 1'b0, k[4]);
      adcEn = k[5]; muxChan = k[3:0];
      #1;
      chk("R8 useMux", {3'b0, negUseMux}, {3'b0, k[4] & ~k[5]});
      chk("R8 chan", negChan, (k[4] & ~k[5]) ? k[3:0] : 4'd0);
    end
    adcEn = 0;

    // R9 spurious flag on mode change
    cmpRaw = 0; tick(4);
    cfg(2'b11, 1'b1, 1'b0); tick(2); w1c(1'b1);
    chk("R9 pre", {3'b0, irqReq}, 4'd0);
    cfg(2'b10, 1'b1, 1'b0); tick(1);
    chk("R9 spurious flag", {3'b0, flag}, 4'd1);
    chk("R9 spurious irq", {3'b0, irqReq}, 4'd1);
    // safe sequence
    cfg(2'b11, 1'b0, 1'b0); tick(2); w1c(1'b1);
    cfg(2'b10, 1'b0, 1'b0); tick(2); w1c(1'b1);
    cfg(2'b10, 1'b1, 1'b0); tick(2);
    chk("R9 safe irq", {3'b0, irqReq}, 4'd0);

    finish_run();
  end
endmodule